// File: doc/BRIEF.md
# Interleaved Dual-Channel Converter Input Latch

This block is the digital front end of a two-channel converter whose channels share one 12-bit parallel bus. Samples for the two channels alternate on the bus, and one clock splits them. The first channel is captured on the rising clock edge and the second on the falling edge. Each enabled rising edge hands the previously captured pair to the converter core and pulses an update strobe.

An active-high chip select lets several such blocks share one bus, each taking only some of the pairs. Chip select takes effect only at a rising clock edge. Once it is registered high, the internal latch clock is frozen and no bus data is taken. When it is released, the release is also registered at a rising edge. The first capture after that is the second channel, on the next falling edge. The next rising edge then presents the old first-channel sample together with the new second-channel sample. A system that interleaves these blocks must therefore scramble its bus pairs so that the right values meet at the outputs. An active-high power-down gates the latch clock in the same way and freezes the output codes.

Top module: `dacPairLatch`

## Requirements
- R1: While rstN is low (asynchronous, active low), chan1Code, chan2Code and updStrobe are zero. Reset leaves the block deselected, so the first rising edge after release transfers and captures nothing.
- R2: On a rising clk edge with the latch clock enabled, the bus value present at that edge is stored as the next first-channel sample.
- R3: On a falling clk edge with the latch clock enabled, the bus value present at that edge is stored as the next second-channel sample.
- R4: On each rising edge with the latch clock enabled, chan1Code takes the first-channel sample stored at the previous enabled rising edge. At the same edge, chan2Code takes the second-channel sample stored at the falling edge just before.
- R5: A high level on csIn is registered at the next rising edge, and that edge still transfers normally. From then on, no edge captures data and chan1Code and chan2Code keep their values.
- R6: After csIn (or pdIn) returns low, the rising edge that registers the release transfers nothing. The following falling edge captures the second channel. The next rising edge outputs the stale first-channel sample with the new second-channel sample, and captures new first-channel data.
- R7: pdIn high gates the latch clock exactly like csIn high, and chan1Code and chan2Code hold their last values while it is in effect.
- R8: updStrobe is high for exactly the clock cycle after each rising edge that transfers a pair to the outputs, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; rising edge for channel 1, falling edge for channel 2 |
| rstN | input | 1 | Asynchronous active-low reset |
| csIn | input | 1 | Chip select, high suppresses latching |
| pdIn | input | 1 | Power-down, high suppresses latching and freezes outputs |
| dataIn | input | 12 | Shared sample bus |
| chan1Code | output | 12 | Code presented to converter channel 1 |
| chan2Code | output | 12 | Code presented to converter channel 2 |
| updStrobe | output | 1 | One-cycle pulse after each output transfer |

## Verification
Two things can fall on the same rising edge. One is the registering of a chip-select change. The other is a pair transfer, which uses the enable state from before that edge. The bench raises csIn in the cycle just before an edge where a transfer is due. It then checks that this edge still moves the pair and pulses the strobe, and that the next edge freezes both. On release, it checks that the edge which registers the low level moves nothing. The output after that must pair the stale first-channel sample with the fresh second-channel one.

// File: rtl/dacLatchPkg.sv
package dacLatchPkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic enRise;  // rising-edge capture and transfer allowed
    logic enFall;  // falling-edge capture allowed
  } latchCtl_t;
endpackage

// File: rtl/dacLatchCtrl.sv
module dacLatchCtrl
  import dacLatchPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      csIn,
  input  logic      pdIn,
  output latchCtl_t ctl,
  output logic      updStrobe
);
  // registered gate: 1 freezes the internal latch clock high
  logic holdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg   <= 1'b1;
      updStrobe <= 1'b0;
    end else begin
      // transfer at this edge uses the gate state from before it
      updStrobe <= !holdReg;
      holdReg   <= csIn | pdIn;
    end
  end

  always_comb begin
    ctl.enRise = !holdReg;
    ctl.enFall = !holdReg;
  end
endmodule

// File: rtl/dacLatchPath.sv
module dacLatchPath
  import dacLatchPkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  latchCtl_t     ctl,
  input  logic [DW-1:0] dataIn,
  output logic [DW-1:0] out1,
  output logic [DW-1:0] out2
);
  logic [DW-1:0] ch1Lat;
  logic [DW-1:0] ch2Lat;

  // channel 2 capture on the falling edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN)           ch2Lat <= '0;
    else if (ctl.enFall) ch2Lat <= dataIn;
  end

  // channel 1 capture and pair transfer on the rising edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ch1Lat <= '0;
      out1   <= '0;
      out2   <= '0;
    end else if (ctl.enRise) begin
      out1   <= ch1Lat;
      out2   <= ch2Lat;
      ch1Lat <= dataIn;
    end
  end
endmodule

// File: rtl/dacPairLatch.sv
module dacPairLatch
  import dacLatchPkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csIn,
  input  logic          pdIn,
  input  logic [DW-1:0] dataIn,
  output logic [DW-1:0] chan1Code,
  output logic [DW-1:0] chan2Code,
  output logic          updStrobe
);
  latchCtl_t ctl;

  dacLatchCtrl uCtrl (
    .clk(clk), .rstN(rstN), .csIn(csIn), .pdIn(pdIn),
    .ctl(ctl), .updStrobe(updStrobe)
  );

  dacLatchPath #(.DW(DW)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataIn(dataIn),
    .out1(chan1Code), .out2(chan2Code)
  );
endmodule

// File: rtl/dacPairLatchChk.sv
module dacPairLatchChk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rstN,
  input logic          csIn,
  input logic          pdIn,
  input logic          enRise,
  input logic          updStrobe,
  input logic [DW-1:0] out1,
  input logic [DW-1:0] out2
);
  p_cs_gates_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(csIn) |-> !enRise);

  p_pd_gates_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(pdIn) |-> !enRise);

  p_outs_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    !updStrobe |-> ($stable(out1) && $stable(out2)));

  p_resume_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enRise) |-> !updStrobe);

  p_strobe_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    updStrobe |-> $past(enRise));
endmodule

bind dacPairLatch dacPairLatchChk #(.DW(DW)) uChk (
  .clk(clk), .rstN(rstN), .csIn(csIn), .pdIn(pdIn),
  .enRise(ctl.enRise), .updStrobe(updStrobe),
  .out1(chan1Code), .out2(chan2Code)
);

// File: tb/sim_dacPairLatch.sv
module sim_dacPairLatch;
  localparam int DW = 12;
  localparam int NROW = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csIn = 1'b1;
  logic pdIn = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] chan1Code, chan2Code;
  logic updStrobe;

  int runCount = 0;
  int failCount = 0;

  always #10 clk = ~clk;

  dacPairLatch #(.DW(DW)) u0 (
    .clk(clk), .rstN(rstN), .csIn(csIn), .pdIn(pdIn), .dataIn(dataIn),
    .chan1Code(chan1Code), .chan2Code(chan2Code), .updStrobe(updStrobe)
  );

  // row: {cs, pd, req, exp1, exp2, expStrobe}; checked just after the row's
  // rising edge, then cs/pd and ch2 data (0x200+i) are driven, and ch1 data
  // (0x100+i) after the falling edge
  typedef struct packed {
    logic    cs;
    logic    pd;
    logic [3:0] req;
    logic [11:0] e1;
    logic [11:0] e2;
    logic    es;
  } row_t;

  localparam row_t ROWS [NROW] = '{
    '{1'b0, 1'b0, 4'd1, 12'h000, 12'h000, 1'b0}, // R1 first edge after reset idle
    '{1'b0, 1'b0, 4'd1, 12'h000, 12'h000, 1'b0}, // R1 release registered
    '{1'b0, 1'b0, 4'd6, 12'h000, 12'h201, 1'b1}, // R6 stale ch1 with new ch2
    '{1'b0, 1'b0, 4'd2, 12'h101, 12'h202, 1'b1}, // R2 streaming
    '{1'b1, 1'b0, 4'd3, 12'h102, 12'h203, 1'b1}, // R3 streaming, cs rises
    '{1'b1, 1'b0, 4'd5, 12'h103, 12'h204, 1'b1}, // R5 edge registering cs still moves
    '{1'b0, 1'b0, 4'd5, 12'h103, 12'h204, 1'b0}, // R5 frozen
    '{1'b0, 1'b0, 4'd6, 12'h103, 12'h204, 1'b0}, // R6 release edge moves nothing
    '{1'b0, 1'b0, 4'd6, 12'h104, 12'h207, 1'b1}, // R6 stale ch1 pairing
    '{1'b0, 1'b1, 4'd4, 12'h107, 12'h208, 1'b1}, // R4 pd rises
    '{1'b0, 1'b1, 4'd7, 12'h108, 12'h209, 1'b1}, // R7 edge registering pd moves
    '{1'b0, 1'b0, 4'd7, 12'h108, 12'h209, 1'b0}, // R7 held
    '{1'b0, 1'b0, 4'd7, 12'h108, 12'h209, 1'b0}, // R7 release edge
    '{1'b0, 1'b0, 4'd6, 12'h109, 12'h20C, 1'b1}, // R6 after power-down
    '{1'b0, 1'b0, 4'd4, 12'h10C, 12'h20D, 1'b1}  // R4 streaming again
  };

  function automatic string reqName(input logic [3:0] id);
    case (id)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    runCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    failCount++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end

  initial begin
    // R1 reset state
    #5;
    check("R1", "out1 in reset", chan1Code, '0);
    check("R1", "out2 in reset", chan2Code, '0);
    check("R1", "strobe in reset", {11'b0, updStrobe}, '0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    #2 rstN = 1'b1;

    for (int i = 0; i < NROW; i++) begin
      @(posedge clk);
      #1;
      check(reqName(ROWS[i].req), $sformatf("out1 row %0d", i), chan1Code, ROWS[i].e1);
      check(reqName(ROWS[i].req), $sformatf("out2 row %0d", i), chan2Code, ROWS[i].e2);
      check("R8", $sformatf("strobe row %0d", i), {11'b0, updStrobe}, {11'b0, ROWS[i].es});
      #1;
      csIn   = ROWS[i].cs;
      pdIn   = ROWS[i].pd;
      dataIn = DW'(12'h200 + i);
      @(negedge clk);
      #2 dataIn = DW'(12'h100 + i);
    end

    // R1 asynchronous reset in mid-stream
    @(negedge clk);
    #3 rstN = 1'b0;
    #1;
    check("R1", "out1 async reset", chan1Code, '0);
    check("R1", "out2 async reset", chan2Code, '0);
    check("R1", "strobe async reset", {11'b0, updStrobe}, '0);
    @(negedge clk);
    #2 rstN = 1'b1;
    csIn = 1'b0;
    dataIn = 12'hABC;
    @(posedge clk);
    #1;
    // R1 deselected after reset: no transfer on first edge
    check("R1", "strobe after release", {11'b0, updStrobe}, '0);
    check("R1", "out1 after release", chan1Code, '0);

    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end
endmodule